// File: doc/BRIEF.md
# Interrupt Status and Coalescing Controller

This block gathers interrupt events from several sources into one status word and drives a single level-sensitive interrupt line. Each source has a fixed clearing style, chosen by a parameter mask. A sticky bit is set by an event and stays set until software reads the main status location. A level bit follows its source and is not affected by any read. A second read location returns the same status word without side effects, so software can inspect pending causes without losing them.

Software writes a per-source enable mask and a control word. The control word holds a global enable, a hold-off period, a per-source bypass mask and a small-frame bypass mode, plus a two-bit command that starts or stops a hold-off timer. While the timer runs, the line stays low, so a burst of frames can be folded into one interrupt. Chosen sources can still raise the line during the hold-off: those marked in the bypass mask, and, when the mode is on, a receive-done event that arrives flagged as a small frame.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the status word, the enable mask, the control fields and `irq_o` are all zero. Register addresses are: 0 main status, 1 shadow status, 2 enable mask, 3 control.
- R2: A sticky bit (parameter `COR_MASK` bit set; bits 3:0 by default) is set one cycle after its `src_i` bit is high. It stays set until a read of address 0, which returns the set value and leaves the bit zero after that cycle.
- R3: A level bit (bits 7:4 by default) shows the registered value of its `src_i` bit. A read of address 0 does not clear it.
- R4: A read of address 1 returns the same word as address 0 and clears nothing.
- R5: When an event on a sticky bit and a read of address 0 happen in the same cycle, the bit is set after that cycle.
- R6: `irq_o` is a register. It is high one cycle after a status bit is set whose enable bit (address 2, bit i = source i) is set, if the global enable (control bit 2) is also set. Otherwise it is low.
- R7: Control word layout: bits 1:0 command, bit 2 global enable, bit 3 small-frame mode, bits 11:4 hold-off period, bits 19:12 bypass mask. A read of address 3 returns these fields with bits 1:0 as zero. Command 01 or 11 loads the hold-off timer with the period. While the timer is nonzero, `irq_o` stays low for non-bypassing sources.
- R8: The timer decrements once every `PRESC_DIV` cycles (4 by default), counted from the load. After a load of period P at clock edge E0, `irq_o` is low through edge E0+P*PRESC_DIV. It is high at the next edge if enabled status is pending.
- R9: Command 00 leaves the timer unchanged. Command 10 clears the timer at once.
- R10: A source whose bypass bit is set raises `irq_o` while the timer is running. The timing is the same as in R6.
- R11: With small-frame mode on, a `src_i[RX_IDX]` event (bit 0 by default) that comes with `small_frame_i` high raises `irq_o` despite the timer. The same event without `small_frame_i`, or any event with the mode off, is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Per-source event or level inputs |
| small_frame_i | input | 1 | Qualifies a receive-done event as a small frame |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | NUM_SRC+TIMER_W+4 | Write data |
| reg_rdata_o | output | NUM_SRC+TIMER_W+4 | Read data, combinational from address |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two things can fall in the same cycle here: a clearing read of the main status and a new event on a sticky bit. The bench drives the read strobe and the source pulse on the same edge. It then reads the shadow location, which has no side effects, and the event must still be recorded. A second case pits the hold-off timer against pending status. The line is sampled on the exact edge where the timer reaches zero and on the edge after it, so an off-by-one in the prescaler or in the output register shows up.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT   = 2'd0,
    ADDR_SHADOW = 2'd1,
    ADDR_ENABLE = 2'd2,
    ADDR_CTRL   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    TMR_KEEP  = 2'b00,
    TMR_LOAD  = 2'b01,
    TMR_STOP  = 2'b10,
    TMR_LOAD2 = 2'b11
  } tmr_cmd_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int          NUM_SRC  = 8,
  parameter logic [63:0] COR_MASK = 64'h0F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] st_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (COR_MASK[i]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        st_q[i] <= 1'b0;
        else if (src_i[i])  st_q[i] <= 1'b1;  // event beats the clearing read
        else if (rd_clr_i)  st_q[i] <= 1'b0;
      end

      // R2
      cor_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q[i] && !rd_clr_i) |=> st_q[i]);
      // R5
      evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i[i] && rd_clr_i) |=> st_q[i]);
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[i] <= 1'b0;
        else         st_q[i] <= src_i[i];
      end

      // R3
      level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (st_q[i] == $past(src_i[i])));
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/irq_mask_timer.sv
module irq_mask_timer #(
  parameter int TIMER_W   = 8,
  parameter int PRESC_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               stop_i,
  input  logic [TIMER_W-1:0] period_i,
  output logic               running_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESC_DIV - 1);

  logic [PW-1:0]      presc_q;
  logic [TIMER_W-1:0] cnt_q;
  logic               tick;

  assign tick = (presc_q == PMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else if (load_i) begin
      cnt_q   <= period_i;
      presc_q <= '0;
    end else if (stop_i) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else if (cnt_q != '0) begin
      if (tick) begin
        presc_q <= '0;
        cnt_q   <= cnt_q - TIMER_W'(1);
      end else begin
        presc_q <= presc_q + PW'(1);
      end
    end else begin
      presc_q <= '0;
    end
  end

  assign running_o = (cnt_q != '0);

  // R7
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(period_i)));
  // R9
  tmr_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> !running_o);
  // R8
  tmr_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !stop_i) |=> (cnt_q <= $past(cnt_q)));
  // R8
  tmr_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !stop_i && presc_q != PMAX) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
  parameter int NUM_SRC = 8,
  parameter int RX_IDX  = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] bypass_i,
  input  logic               glob_en_i,
  input  logic               small_set_i,
  input  logic               running_i,
  output logic               irq_o
);
  logic               small_q;
  logic               irq_q;
  logic [NUM_SRC-1:0] pass;
  logic [NUM_SRC-1:0] allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  small_q <= 1'b0;
    else if (small_set_i)         small_q <= 1'b1;
    else if (!status_i[RX_IDX])   small_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pass
    if (i == RX_IDX) begin : g_rx
      assign pass[i] = bypass_i[i] | small_q;
    end else begin : g_other
      assign pass[i] = bypass_i[i];
    end
  end

  assign allow = status_i & enable_i & (~{NUM_SRC{running_i}} | pass);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= glob_en_i & (|allow);
  end

  assign irq_o = irq_q;

  // R6
  irq_needs_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(glob_en_i));
  // R6
  irq_needs_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & enable_i) == '0) |=> !irq_q);
  // R7
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && ((status_i & enable_i & bypass_i) == '0) && !small_q) |=> !irq_q);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int          NUM_SRC   = 8,
  parameter int          TIMER_W   = 8,
  parameter int          PRESC_DIV = 4,
  parameter int          RX_IDX    = 0,
  parameter logic [63:0] COR_MASK  = 64'h0F
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-1:0]           src_i,
  input  logic                         small_frame_i,
  input  logic                         reg_rd_i,
  input  logic                         reg_wr_i,
  input  logic [1:0]                   reg_addr_i,
  input  logic [NUM_SRC+TIMER_W+3:0]   reg_wdata_i,
  output logic [NUM_SRC+TIMER_W+3:0]   reg_rdata_o,
  output irq_o
);
  localparam int DW      = NUM_SRC + TIMER_W + 4;
  localparam int PER_LSB = 4;
  localparam int DD_LSB  = PER_LSB + TIMER_W;

  reg_addr_e          addr;
  tmr_cmd_e           cmd;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] en_q, dd_q;
  logic [TIMER_W-1:0] period_q;
  logic               gen_q, small_mode_q;
  logic               wr_ctrl, rd_clr, tmr_load, tmr_stop, running, small_set;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign cmd     = tmr_cmd_e'(reg_wdata_i[1:0]);
  assign wr_ctrl = reg_wr_i && (addr == ADDR_CTRL);
  assign rd_clr  = reg_rd_i && (addr == ADDR_STAT);
  assign tmr_load = wr_ctrl && (cmd == TMR_LOAD || cmd == TMR_LOAD2);
  assign tmr_stop = wr_ctrl && (cmd == TMR_STOP);
  assign small_set = src_i[RX_IDX] && small_frame_i && small_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= '0;
      dd_q         <= '0;
      period_q     <= '0;
      gen_q        <= 1'b0;
      small_mode_q <= 1'b0;
    end else if (reg_wr_i) begin
      case (addr)
        ADDR_ENABLE: en_q <= reg_wdata_i[NUM_SRC-1:0];
        ADDR_CTRL: begin
          gen_q        <= reg_wdata_i[2];
          small_mode_q <= reg_wdata_i[3];
          period_q     <= reg_wdata_i[DD_LSB-1:PER_LSB];
          dd_q         <= reg_wdata_i[DW-1:DD_LSB];
        end
        default: ;
      endcase
    end
  end

  // the period written in the same cycle is the one loaded
  irq_status_bank #(.NUM_SRC(NUM_SRC), .COR_MASK(COR_MASK)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .rd_clr_i (rd_clr),
    .status_o (status)
  );

  irq_mask_timer #(.TIMER_W(TIMER_W), .PRESC_DIV(PRESC_DIV)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .stop_i    (tmr_stop),
    .period_i  (reg_wdata_i[DD_LSB-1:PER_LSB]),
    .running_o (running)
  );

  irq_out_gate #(.NUM_SRC(NUM_SRC), .RX_IDX(RX_IDX)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .status_i    (status),
    .enable_i    (en_q),
    .bypass_i    (dd_q),
    .glob_en_i   (gen_q),
    .small_set_i (small_set),
    .running_i   (running),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      ADDR_STAT, ADDR_SHADOW: reg_rdata_o[NUM_SRC-1:0] = status;
      ADDR_ENABLE:            reg_rdata_o[NUM_SRC-1:0] = en_q;
      ADDR_CTRL:              reg_rdata_o = {dd_q, period_q, small_mode_q, gen_q, 2'b00};
      default:                reg_rdata_o = '0;
    endcase
  end

  // R4
  shadow_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && addr == ADDR_SHADOW) |=>
      ((status & COR_MASK[NUM_SRC-1:0]) & $past(status & COR_MASK[NUM_SRC-1:0]))
        == $past(status & COR_MASK[NUM_SRC-1:0]));
endmodule

// File: tb/tb_irq_coalesce.sv
module tb_irq_coalesce;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  src_i = '0;
  logic        small_frame_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [19:0] reg_wdata_i = '0;
  logic [19:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  irq_coalesce dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .small_frame_i(small_frame_i),
    .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [19:0] cw(input logic [1:0] code, input logic g, input logic s,
                                     input logic [7:0] p, input logic [7:0] d);
    return {d, p, s, g, code};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [19:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [19:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1;
    d = reg_rdata_o;
    step();
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input logic s);
    src_i = m; small_frame_i = s;
    step();
    src_i = '0; small_frame_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [19:0] d;
    chk("R1 irq", irq_o, 0);
    rd(2'd1, d); chk("R1 status", d, 0);
    rd(2'd2, d); chk("R1 enable", d, 0);
    rd(2'd3, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_sticky();
    logic [19:0] d;
    pulse(8'h04, 1'b0);
    rd(2'd1, d); chk("R4 shadow read", d, 20'h04);
    rd(2'd1, d); chk("R4 shadow again", d, 20'h04);
    rd(2'd0, d); chk("R2 main read value", d, 20'h04);
    rd(2'd1, d); chk("R2 cleared after read", d, 0);
  endtask

  task automatic t_level();
    logic [19:0] d;
    src_i = 8'h20;
    step();
    rd(2'd0, d); chk("R3 level set", d, 20'h20);
    rd(2'd1, d); chk("R3 read keeps level", d, 20'h20);
    src_i = '0;
    step();
    rd(2'd1, d); chk("R3 follows source", d, 0);
  endtask

  task automatic t_collide();
    logic [19:0] d;
    reg_rd_i = 1'b1; reg_addr_i = 2'd0; src_i = 8'h02;
    step();
    reg_rd_i = 1'b0; src_i = '0;
    rd(2'd1, d); chk("R5 event wins", d, 20'h02);
    rd(2'd0, d);
    rd(2'd1, d); chk("R5 later read clears", d, 0);
  endtask

  task automatic t_gate();
    logic [19:0] d;
    wr(2'd2, 20'h04);
    pulse(8'h04, 1'b0);
    step(); step();
    chk("R6 no global enable", irq_o, 0);
    wr(2'd3, cw(2'b00, 1'b1, 1'b0, 8'd0, 8'd0));
    chk("R6 not yet", irq_o, 0);
    step();
    chk("R6 asserted", irq_o, 1);
    rd(2'd0, d);
    step();
    chk("R6 drops after clear", irq_o, 0);
    pulse(8'h08, 1'b0);
    step(); step();
    chk("R6 disabled source", irq_o, 0);
    rd(2'd0, d);
  endtask

  task automatic t_timer();
    logic [19:0] d;
    bit ok = 1'b1;
    wr(2'd3, cw(2'b01, 1'b1, 1'b0, 8'd3, 8'd0));
    pulse(8'h04, 1'b0);
    for (int k = 0; k < 11; k++) begin
      step();
      if (irq_o !== 1'b0) ok = 1'b0;
    end
    chk("R7 held while running", ok, 1);
    step();
    chk("R8 released after expiry", irq_o, 1);
    rd(2'd3, d); chk("R7 ctrl readback", d, 20'h00034);
    rd(2'd0, d);
    step();
  endtask

  task automatic t_keep_stop();
    logic [19:0] d;
    bit ok = 1'b1;
    wr(2'd3, cw(2'b11, 1'b1, 1'b0, 8'd3, 8'd0));
    step(); step(); step();
    wr(2'd3, cw(2'b00, 1'b1, 1'b0, 8'd3, 8'd0));
    pulse(8'h04, 1'b0);
    for (int k = 0; k < 7; k++) begin
      step();
      if (irq_o !== 1'b0) ok = 1'b0;
    end
    chk("R9 code 00 keeps timer", ok, 1);
    step();
    chk("R8 code 11 expiry", irq_o, 1);
    rd(2'd0, d);
    step();
    wr(2'd3, cw(2'b01, 1'b1, 1'b0, 8'd3, 8'd0));
    pulse(8'h04, 1'b0);
    chk("R9 held before stop", irq_o, 0);
    wr(2'd3, cw(2'b10, 1'b1, 1'b0, 8'd3, 8'd0));
    chk("R9 stop edge", irq_o, 0);
    step();
    chk("R9 code 10 clears timer", irq_o, 1);
    rd(2'd0, d);
    step();
  endtask

  task automatic t_bypass();
    logic [19:0] d;
    wr(2'd2, 20'h06);
    wr(2'd3, cw(2'b01, 1'b1, 1'b0, 8'd20, 8'h02));
    pulse(8'h04, 1'b0);
    step(); step();
    chk("R10 plain source held", irq_o, 0);
    pulse(8'h02, 1'b0);
    chk("R10 bypass not yet", irq_o, 0);
    step();
    chk("R10 bypass source asserts", irq_o, 1);
    wr(2'd3, cw(2'b10, 1'b1, 1'b0, 8'd20, 8'h02));
    rd(2'd0, d); chk("R10 status", d, 20'h06);
    step();
    chk("R10 cleared", irq_o, 0);
  endtask

  task automatic t_small();
    logic [19:0] d;
    wr(2'd2, 20'h01);
    wr(2'd3, cw(2'b01, 1'b1, 1'b1, 8'd20, 8'd0));
    pulse(8'h01, 1'b0);
    step(); step();
    chk("R11 normal frame held", irq_o, 0);
    rd(2'd0, d);
    step();
    pulse(8'h01, 1'b1);
    step();
    chk("R11 small frame bypasses", irq_o, 1);
    wr(2'd3, cw(2'b10, 1'b1, 1'b1, 8'd20, 8'd0));
    rd(2'd0, d);
    step();
    wr(2'd3, cw(2'b01, 1'b1, 1'b0, 8'd20, 8'd0));
    pulse(8'h01, 1'b1);
    step(); step();
    chk("R11 mode off held", irq_o, 0);
    wr(2'd3, cw(2'b10, 1'b1, 1'b0, 8'd20, 8'd0));
    rd(2'd0, d);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    t_reset();
    t_sticky();
    t_level();
    t_collide();
    t_gate();
    t_timer();
    t_keep_stop();
    t_bypass();
    t_small();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule